// File: doc/BRIEF.md
# Strided Line Read Address Generator

This block turns one transfer description into a series of memory read requests, one per line of an image or buffer. A start pulse supplies a 48-bit base address, a total byte count and a packed geometry word that holds both the line length and the line pitch. The block then issues one request per line. Each request carries a source address and a byte length and uses a valid/ready handshake. The block also reports where each line lands in the destination buffer, as a running byte offset.

After each accepted request, the source address moves forward by the pitch and the destination offset moves forward by the line length. The block ends with a one-cycle done pulse once the whole count has been consumed. It ends instead with a one-cycle error pulse in three cases: a read fault reported by the memory side, a line length of zero, or a line length that no longer fits in the bytes that remain. The data path that moves the bytes sits outside this block. It is expected to raise the fault input when a read fails.

Top module: `line_stride_gen`

## Requirements
- R1: During reset and after its release, `req_valid_o`, `done_o` and `err_o` are low until a start is accepted.
- R2: The line length is bits [17:0] of `geom_i`. The source pitch is bits [31:18] of `geom_i` multiplied by 16.
- R3: A start accepted while idle raises `req_valid_o` in the next cycle. The first request has address equal to the base, length equal to the line length, and destination offset 0.
- R4: For every accepted request (valid and ready high, no fault), the next request's address is the previous address plus the pitch, and its destination offset is the previous offset plus the line length.
- R5: While valid is high and ready is low, the request stays valid and its address, length and offset stay unchanged.
- R6: When the total is an exact multiple of the line length, exactly total/line requests are issued. `done_o` pulses in the cycle after the final request is accepted.
- R7: A start with a total of zero issues no request and pulses `done_o` in the next cycle.
- R8: If the line length is zero, or larger than the bytes still remaining, no further request is issued and `err_o` pulses instead. This is checked at start and after each accepted line.
- R9: `rd_err_i` high while a request is pending ends the sequence: `err_o` pulses in the next cycle and no further request is issued.
- R10: A start pulse while a sequence is in progress is ignored and does not change the running sequence.
- R11: Source addresses wrap modulo 2^48.
- R12: `done_o` and `err_o` are never high together, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; parameters sampled with it |
| base_addr_i | input | 48 | Source address of the first line |
| total_i | input | 32 | Total bytes to transfer |
| geom_i | input | 32 | Packed line length [17:0] and pitch/16 [31:18] |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted by memory side |
| req_addr_o | output | 48 | Source address of the current line |
| req_len_o | output | 18 | Bytes to read for the current line |
| dst_off_o | output | 32 | Destination byte offset of the current line |
| rd_err_i | input | 1 | Read fault from the memory side |
| done_o | output | 1 | One-cycle pulse on normal completion |
| err_o | output | 1 | One-cycle pulse on abnormal termination |

## Verification
The bench aims at the termination corners. A total of zero must finish without any request; a generator that tests the line length first would wrongly raise an error. A zero line length must end with an error, not spin forever. A count that is not a multiple of the line length must stop after the last whole line, not underflow into a huge remaining count. Read faults are injected on the first line and on a later line, and must cut the stream short. Random backpressure, a base address just below 2^48, and the widest line and pitch fields expose three more kinds of error: a request that changes while stalled, an address carried past bit 47, and a pitch field taken from the wrong bits or left unscaled. A stray start in the middle of a run must leave the expected request stream unchanged.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lsg_state_e;

  typedef enum logic [1:0] {
    VD_GO   = 2'd0,
    VD_DONE = 2'd1,
    VD_BAD  = 2'd2
  } lsg_verdict_e;
endpackage

// File: rtl/lsg_geom_unpack.sv
module lsg_geom_unpack #(
  parameter int LEN_W    = 18,
  parameter int STRIDE_W = 14,
  parameter int SHIFT    = 4,
  parameter int ADDR_W   = 48
) (
  input  logic [LEN_W+STRIDE_W-1:0] geom_i,
  output logic [LEN_W-1:0]          line_o,
  output logic [ADDR_W-1:0]         pitch_o
);
  localparam int PAD_W = ADDR_W - STRIDE_W - SHIFT;

  // Pitch field sits above the line field and counts 16-byte units.
  assign line_o  = geom_i[LEN_W-1:0];
  assign pitch_o = {{PAD_W{1'b0}}, geom_i[LEN_W +: STRIDE_W], {SHIFT{1'b0}}};
endmodule

// File: rtl/lsg_verdict.sv
module lsg_verdict
  import lsg_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 18
) (
  input  logic [CNT_W-1:0] remain_i,
  input  logic [LEN_W-1:0] line_i,
  output lsg_verdict_e     verdict_o
);
  logic [CNT_W-1:0] line_ext;

  assign line_ext = {{(CNT_W-LEN_W){1'b0}}, line_i};

  // Zero remaining wins over a bad line length, so an empty transfer completes.
  always_comb begin
    if (remain_i == '0) begin
      verdict_o = VD_DONE;
    end else if ((line_i == '0) || (line_ext > remain_i)) begin
      verdict_o = VD_BAD;
    end else begin
      verdict_o = VD_GO;
    end
  end
endmodule

// File: rtl/line_stride_gen.sv
module line_stride_gen
  import lsg_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int CNT_W    = 32,
  parameter int LEN_W    = 18,
  parameter int STRIDE_W = 14,
  parameter int SHIFT    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [ADDR_W-1:0]         base_addr_i,
  input  logic [CNT_W-1:0]          total_i,
  input  logic [LEN_W+STRIDE_W-1:0] geom_i,
  output logic                      req_valid_o,
  input  logic                      req_ready_i,
  output logic [ADDR_W-1:0]         req_addr_o,
  output logic [LEN_W-1:0]          req_len_o,
  output logic [CNT_W-1:0]          dst_off_o,
  input  logic                      rd_err_i,
  output logic                      done_o,
  output logic                      err_o
);
  localparam int EXT_W = CNT_W - LEN_W;

  // Reset release synchroniser.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // State registers and their next values.
  lsg_state_e        state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [CNT_W-1:0]  dst_q, dst_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  line_q, line_d;
  logic [ADDR_W-1:0] pitch_q, pitch_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              ctx_en;

  logic [LEN_W-1:0]  new_line;
  logic [ADDR_W-1:0] new_pitch;
  logic [CNT_W-1:0]  rem_after;
  lsg_verdict_e      vd_start, vd_step;

  lsg_geom_unpack #(
    .LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
  ) u_unpack (
    .geom_i (geom_i),
    .line_o (new_line),
    .pitch_o(new_pitch)
  );

  assign rem_after = rem_q - {{EXT_W{1'b0}}, line_q};

  lsg_verdict #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_vd_start (
    .remain_i (total_i),
    .line_i   (new_line),
    .verdict_o(vd_start)
  );

  lsg_verdict #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_vd_step (
    .remain_i (rem_after),
    .line_i   (line_q),
    .verdict_o(vd_step)
  );

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    line_d  = line_q;
    pitch_d = pitch_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    ctx_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctx_en  = 1'b1;
          src_d   = base_addr_i;
          dst_d   = '0;
          rem_d   = total_i;
          line_d  = new_line;
          pitch_d = new_pitch;
          unique case (vd_start)
            VD_DONE: done_d  = 1'b1;
            VD_BAD:  err_d   = 1'b1;
            default: state_d = ST_RUN;
          endcase
        end
      end
      ST_RUN: begin
        if (rd_err_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (req_ready_i) begin
          ctx_en = 1'b1;
          src_d  = src_q + pitch_q;
          dst_d  = dst_q + {{EXT_W{1'b0}}, line_q};
          rem_d  = rem_after;
          unique case (vd_step)
            VD_DONE: begin state_d = ST_IDLE; done_d = 1'b1; end
            VD_BAD:  begin state_d = ST_IDLE; err_d  = 1'b1; end
            default: state_d = ST_RUN;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      line_q  <= '0;
      pitch_q <= '0;
    end else if (ctx_en) begin
      src_q   <= src_d;
      dst_q   <= dst_d;
      rem_q   <= rem_d;
      line_q  <= line_d;
      pitch_q <= pitch_d;
    end
  end

  assign req_valid_o = (state_q == ST_RUN);
  assign req_addr_o  = src_q;
  assign req_len_o   = line_q;
  assign dst_off_o   = dst_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R12
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(done_o && err_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && !rd_err_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(dst_off_o) && $stable(req_len_o)));

  // R9
  rd_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_o && rd_err_i) |=> (err_o && !req_valid_o));

  // R4
  dst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_o && req_ready_i && !rd_err_i) |=>
      (!req_valid_o ||
       (dst_off_o == $past(dst_off_o) + {{EXT_W{1'b0}}, $past(req_len_o)})));
endmodule

// File: tb/line_stride_gen_bench.sv
module line_stride_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [47:0] base_addr_i = '0;
  logic [31:0] total_i = '0;
  logic [31:0] geom_i = '0;
  logic        req_ready_i = 1'b0;
  logic        rd_err_i = 1'b0;
  logic        req_valid_o;
  logic [47:0] req_addr_o;
  logic [17:0] req_len_o;
  logic [31:0] dst_off_o;
  logic        done_o;
  logic        err_o;

  always #4 clk_i = ~clk_i;

  line_stride_gen u_line_stride_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .base_addr_i(base_addr_i), .total_i(total_i), .geom_i(geom_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .dst_off_o(dst_off_o),
    .rd_err_i(rd_err_i), .done_o(done_o), .err_o(err_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    acc_cnt = 0;
  int    end_cnt = 0;
  bit    mon_on = 1'b0;
  string cur_tag = "R4";
  string end_tag = "R6";

  logic [47:0] q_addr[$];
  logic [17:0] q_len[$];
  logic [31:0] q_off[$];
  bit          q_end[$];

  bit          rnd_rdy = 1'b0;
  bit          hold_rdy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Ready generator, driven after the task-side updates in each cycle.
  always @(posedge clk_i) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready_i = hold_rdy ? 1'b0 : (rnd_rdy ? lfsr[0] : 1'b1);
  end

  // Monitor / scoreboard.
  bit          stall_seen = 1'b0;
  logic [47:0] stall_addr;
  logic [31:0] stall_off;
  bit          prev_end = 1'b0;

  always @(negedge clk_i) begin
    if (mon_on) begin
      if (stall_seen) begin
        chk(req_valid_o && req_addr_o == stall_addr && dst_off_o == stall_off,
            "R5", "stalled request changed", {16'h0, req_addr_o}, {16'h0, stall_addr});
      end
      stall_seen = req_valid_o && !req_ready_i && !rd_err_i;
      stall_addr = req_addr_o;
      stall_off  = dst_off_o;

      if (req_valid_o && req_ready_i) begin
        acc_cnt++;
        if (q_addr.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected request", {16'h0, req_addr_o}, 64'h0);
        end else begin
          logic [47:0] ea;
          logic [17:0] el;
          logic [31:0] eo;
          ea = q_addr.pop_front();
          el = q_len.pop_front();
          eo = q_off.pop_front();
          chk(req_addr_o == ea, cur_tag, "request address", {16'h0, req_addr_o}, {16'h0, ea});
          chk(req_len_o == el && dst_off_o == eo, cur_tag, "length/offset",
              {14'h0, req_len_o, dst_off_o}, {14'h0, el, eo});
        end
      end

      if (done_o || err_o) begin
        end_cnt++;
        chk(!(done_o && err_o) && !prev_end, "R12", "end pulse shape",
            {62'h0, done_o, err_o}, 64'h1);
        if (q_end.size() == 0) begin
          chk(1'b0, end_tag, "unexpected end", {63'h0, done_o}, 64'h0);
        end else begin
          bit e;
          e = q_end.pop_front();
          chk(done_o == e && err_o == !e, end_tag, "end kind (1=done)",
              {63'h0, done_o}, {63'h0, e});
        end
        chk(q_addr.size() == 0, end_tag, "requests missing at end",
            64'(q_addr.size()), 64'h0);
      end
      prev_end = done_o || err_o;
    end
  end

  // Expected stream from the requirements.
  task automatic expect_seq(input logic [47:0] base, input logic [31:0] total,
                            input logic [31:0] geom, input int err_k);
    logic [47:0] a;
    logic [47:0] pitch;
    logic [31:0] rem;
    logic [31:0] off;
    logic [31:0] line;
    int          n;
    a     = base;
    pitch = {34'h0, geom[31:18]} * 48'd16;
    line  = {14'h0, geom[17:0]};
    rem   = total;
    off   = '0;
    n     = 0;
    forever begin
      if (rem == 0) begin q_end.push_back(1'b1); break; end
      if (line == 0 || line > rem) begin q_end.push_back(1'b0); break; end
      if (err_k >= 0 && n == err_k) begin q_end.push_back(1'b0); break; end
      q_addr.push_back(a);
      q_len.push_back(line[17:0]);
      q_off.push_back(off);
      a   = a + pitch;
      off = off + line;
      rem = rem - line;
      n++;
    end
  endtask

  task automatic run_case(input string tag, input string etag, input logic [47:0] base,
                          input logic [31:0] total, input logic [31:0] geom,
                          input bit rnd, input int err_k, input int inj_k);
    int a0;
    int e0;
    cur_tag = tag;
    end_tag = etag;
    rnd_rdy = rnd;
    expect_seq(base, total, geom, err_k);
    a0 = acc_cnt;
    e0 = end_cnt;
    @(posedge clk_i); #1;
    start_i = 1'b1; base_addr_i = base; total_i = total; geom_i = geom;
    @(posedge clk_i); #1;
    start_i = 1'b0; base_addr_i = '1; total_i = '1; geom_i = 32'h0004_0001;
    if (err_k >= 0) begin
      while (acc_cnt - a0 != err_k) begin @(posedge clk_i); #1; end
      hold_rdy = 1'b1; rd_err_i = 1'b1;
      @(posedge clk_i); #1;
      rd_err_i = 1'b0; hold_rdy = 1'b0;
    end
    if (inj_k >= 0) begin
      while (acc_cnt - a0 < inj_k) begin @(posedge clk_i); #1; end
      start_i = 1'b1; base_addr_i = 48'h5555_0000_0000; total_i = 32'd4;
      geom_i = {14'd1, 18'd4};
      @(posedge clk_i); #1;
      start_i = 1'b0;
    end
    while (end_cnt == e0) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
  endtask

  function automatic logic [31:0] mk_geom(input int line, input int sfield);
    return {sfield[13:0], line[17:0]};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet during reset
    chk(!req_valid_o && !done_o && !err_o, "R1", "outputs in reset",
        {61'h0, req_valid_o, done_o, err_o}, 64'h0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R1: outputs quiet after release
    chk(!req_valid_o && !done_o && !err_o, "R1", "outputs after reset",
        {61'h0, req_valid_o, done_o, err_o}, 64'h0);
    mon_on = 1'b1;

    run_case("R3", "R6", 48'h0000_0000_1000, 32'd64, mk_geom(16, 2), 1'b0, -1, -1);
    run_case("R4", "R6", 48'h0002_0000_0010, 32'd60, mk_geom(12, 5), 1'b1, -1, -1);
    run_case("R7", "R7", 48'h0000_0000_3000, 32'd0, mk_geom(16, 1), 1'b0, -1, -1);
    run_case("R8", "R8", 48'h0000_0000_4000, 32'd32, mk_geom(0, 1), 1'b0, -1, -1);
    run_case("R8", "R8", 48'h0000_0000_5000, 32'd8, mk_geom(16, 1), 1'b0, -1, -1);
    run_case("R8", "R8", 48'h0000_0000_6000, 32'd10, mk_geom(4, 1), 1'b1, -1, -1);
    run_case("R9", "R9", 48'h0000_0001_0000, 32'd80, mk_geom(16, 3), 1'b1, 2, -1);
    run_case("R9", "R9", 48'h0000_0001_8000, 32'd80, mk_geom(16, 3), 1'b0, 0, -1);
    run_case("R11", "R6", 48'hFFFF_FFFF_FFE0, 32'd32, mk_geom(8, 1), 1'b0, -1, -1);
    run_case("R10", "R10", 48'h0000_0002_0000, 32'd96, mk_geom(16, 4), 1'b1, -1, 1);
    run_case("R2", "R6", 48'h0000_0000_0000, 32'h0007_FFFE, mk_geom(18'h3FFFF, 14'h3FFF),
             1'b0, -1, -1);

    // R1: quiet again when idle
    @(negedge clk_i);
    chk(!req_valid_o && !done_o && !err_o, "R1", "idle outputs",
        {61'h0, req_valid_o, done_o, err_o}, 64'h0);
    summary();
    $finish;
  end
endmodule